// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block is the digital core of a spread-spectrum clock source. It runs on the reference clock and produces an offset-binary code for a current-output DAC. The analog loop turns that code into a small frequency deflection of the oscillator. Spreading the output clock over a narrow band lowers its emission peak. Two rate-select pins choose the depth of the spread and whether it is centred on the nominal frequency or lies wholly below it. An enable pin turns the modulation off. An active-low power-down pin stops the block and asks the clock output stage to hold its output low.

The code follows a triangle whose segments are exactly one quarter of a modulation period long. The period itself is dithered: it walks up and down a ladder of lengths whose mean is the nominal length. New select and enable values are taken only at the end of a period, where the deviation is zero. The code therefore moves by at most one step per clock, even when the settings change. All pins are asynchronous and pass through a synchroniser before use.

Top module: `sscg_profile_gen`

## Requirements
- R1: `dac_code` is offset binary. 128 means zero deviation, a larger code means a higher frequency, and one code step is 0.025% of the nominal frequency, so 120 steps are 3.0%.
- R2: `rate_sel` selects the spread. 00 gives a ±1.5% centre spread (codes 68..188). 01 gives a ±0.5% centre spread (codes 108..148). 10 gives a down spread to −1.0% (codes 88..128). 11 gives a down spread to −3.0% (codes 8..128). A down spread never produces a code above 128.
- R3: A period of P clocks is split into four quarters of P/4 clocks. Let S be the quarter swing: 60 for selects 00 and 11, 20 for selects 01 and 10. After m clocks into a quarter, the code has moved floor(m·S/(P/4)) from the value it held at the start of that quarter. In a centre spread the quarters go up, down, down, up. In a down spread they go down, down, up, up. The code never changes by more than 1 between clocks.
- R4: With the default parameters, the period lengths after each start are 1600, 1700, 1800, 1900, 2000, 2100, 2200, 2100, 2000, 1900, 1800, 1700, and then the sequence repeats. Successive periods differ by exactly 100 clocks, and the mean length is 1900.
- R5: With the ×8 variant parameter set, the same ladder is scaled to 640..880 in steps of 40 (mean 760), and the first period is 640 clocks.
- R6: A change of `rate_sel` or `mod_en` inside a period leaves the rest of that period unchanged and applies from the next period on.
- R7: A period that starts while `mod_en` is low holds `dac_code` at 128 for the whole period.
- R8: Three clock edges after `pwr_dn_n` falls, `code_valid` is 0, `clk_hold_low` is 1 and `dac_code` is 128. These values hold for as long as power-down lasts, whatever the other pins do.
- R9: `code_valid` rises on the third clock edge after `pwr_dn_n` rises. The code then starts from 128 with a first period of minimum length, using the settings present at release.
- R10: While `rst` is high, and afterwards until power-down is released, `code_valid` is 0, `clk_hold_low` is 1 and `dac_code` is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Spread depth and direction select (asynchronous pin) |
| mod_en | input | 1 | Modulation enable, high to spread (asynchronous pin) |
| pwr_dn_n | input | 1 | Active-low power-down (asynchronous pin) |
| dac_code | output | 8 | Offset-binary deviation code for the DAC |
| code_valid | output | 1 | High while the generator is running |
| clk_hold_low | output | 1 | High forces the downstream clock output low |

## Verification
The hardest case to reach is a settings change that lands mid-period, far from any boundary. The test must then show that the old profile runs to the end of the period and that the new one starts exactly at the next boundary. Because the period length keeps changing, this must happen on a different length each time. The stimulus therefore drives a new select or enable value at half of every period across a whole dither cycle and compares every sample against a closed-form triangle. That comparison also confirms the full ladder of lengths, including the turn at the top and the wrap at the bottom. A power-down dropped into the middle of a period, followed by a release with different settings, covers the restart from zero.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    // Code scale: 120 steps span 3.0 % of nominal frequency
    localparam int CODE_W          = 8;
    localparam logic [CODE_W-1:0] CODE_MID = 8'd128;
    localparam int FULL_SPAN_CODES = 120;
    localparam int AMP_W           = 7;
    localparam int AMP_WIDE        = FULL_SPAN_CODES / 2;
    localparam int AMP_NARROW      = FULL_SPAN_CODES / 6;

    typedef enum logic [1:0] {
        SEL_CTR_WIDE   = 2'b00,
        SEL_CTR_NARROW = 2'b01,
        SEL_DN_SHALLOW = 2'b10,
        SEL_DN_DEEP    = 2'b11
    } rate_sel_e;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_kind_e;

    typedef enum logic [1:0] {
        SEG0 = 2'd0,
        SEG1 = 2'd1,
        SEG2 = 2'd2,
        SEG3 = 2'd3
    } seg_e;

    typedef struct packed {
        rate_sel_e sel;
        logic      en;
    } mod_cfg_t;

    typedef struct packed {
        spread_kind_e     kind;
        logic [AMP_W-1:0] seg_amp;
    } profile_t;

    function automatic profile_t decode_rate(input mod_cfg_t c);
        profile_t p;
        case (c.sel)
            SEL_CTR_WIDE:   begin p.kind = SPREAD_CENTER; p.seg_amp = AMP_W'(AMP_WIDE);   end
            SEL_CTR_NARROW: begin p.kind = SPREAD_CENTER; p.seg_amp = AMP_W'(AMP_NARROW); end
            SEL_DN_SHALLOW: begin p.kind = SPREAD_DOWN;   p.seg_amp = AMP_W'(AMP_NARROW); end
            default:        begin p.kind = SPREAD_DOWN;   p.seg_amp = AMP_W'(AMP_WIDE);   end
        endcase
        if (!c.en) p.seg_amp = '0;
        return p;
    endfunction

    // 1 = code moves upward in this quarter
    function automatic logic seg_dir_up(input spread_kind_e kind, input seg_e seg);
        if (kind == SPREAD_CENTER) return (seg == SEG0) || (seg == SEG3);
        else                       return (seg == SEG2) || (seg == SEG3);
    endfunction

endpackage

// File: rtl/sscg_pin_sync.sv
module sscg_pin_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sscg_period_dither.sv
module sscg_period_dither #(
    parameter int PMIN   = 1600,
    parameter int PSTEP  = 100,
    parameter int LEVELS = 7,
    parameter int QW     = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    output logic [QW-1:0] quarter_len
);

    localparam int IW = (LEVELS > 2) ? $clog2(LEVELS) : 1;
    localparam logic [IW-1:0] TOP = IW'(LEVELS - 1);

    logic [IW-1:0] idx;
    logic          rising;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx    <= '0;
            rising <= 1'b1;
        end else if (advance) begin
            if (rising) begin
                if (idx == TOP) begin
                    rising <= 1'b0;
                    idx    <= idx - IW'(1);
                end else begin
                    idx <= idx + IW'(1);
                end
            end else begin
                if (idx == '0) begin
                    rising <= 1'b1;
                    idx    <= idx + IW'(1);
                end else begin
                    idx <= idx - IW'(1);
                end
            end
        end
    end

    always_comb begin
        quarter_len = QW'((PMIN + int'(idx) * PSTEP) / 4);
    end

endmodule

// File: rtl/sscg_tri_stepper.sv
module sscg_tri_stepper
    import sscg_pkg::*;
#(
    parameter int QW = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic [QW-1:0]            quarter_len,
    input  profile_t                 prof,
    output logic signed [CODE_W-1:0] dev,
    output logic                     period_end
);

    localparam int AW = QW + 1;

    seg_e          seg;
    logic [QW-1:0] cnt;
    logic [QW-1:0] acc;
    logic [AW-1:0] acc_sum;
    logic          carry;
    logic          seg_last;
    logic          dir_up;

    always_comb begin
        seg_last   = (cnt == quarter_len - QW'(1));
        acc_sum    = AW'(acc) + AW'(prof.seg_amp);
        carry      = (acc_sum >= AW'(quarter_len));
        dir_up     = seg_dir_up(prof.kind, seg);
        period_end = run && seg_last && (seg == SEG3);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            seg <= SEG0;
            cnt <= '0;
            acc <= '0;
            dev <= '0;
        end else begin
            if (seg_last) begin
                cnt <= '0;
                seg <= seg.next();
            end else begin
                cnt <= cnt + QW'(1);
            end
            acc <= carry ? QW'(acc_sum - AW'(quarter_len)) : QW'(acc_sum);
            if (carry) dev <= dir_up ? dev + 8'sd1 : dev - 8'sd1;
        end
    end

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen
    import sscg_pkg::*;
#(
    parameter bit X8_VARIANT    = 1'b0,
    parameter int BASE_PMIN     = 1600,
    parameter int BASE_PSTEP    = 100,
    parameter int DITHER_LEVELS = 7,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rate_sel,
    input  logic              mod_en,
    input  logic              pwr_dn_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid,
    output logic              clk_hold_low
);

    localparam int PMIN  = X8_VARIANT ? (BASE_PMIN * 2) / 5 : BASE_PMIN;
    localparam int PSTEP = X8_VARIANT ? (BASE_PSTEP * 2) / 5 : BASE_PSTEP;
    localparam int PMAX  = PMIN + (DITHER_LEVELS - 1) * PSTEP;
    localparam int QW    = $clog2(PMAX / 4 + 1);
    localparam int PIN_W = $bits(rate_sel_e) + 2;
    localparam logic [PIN_W-1:0] PIN_RST = {SEL_CTR_WIDE, 1'b1, 1'b0};

    logic [PIN_W-1:0]         pin_bus;
    logic [PIN_W-1:0]         sync_bus;
    mod_cfg_t                 s_cfg;
    mod_cfg_t                 cfg_q;
    mod_cfg_t                 active_cfg;
    profile_t                 prof;
    logic                     run;
    logic                     valid_q;
    logic                     period_end;
    logic [QW-1:0]            quarter_len;
    logic signed [CODE_W-1:0] dev;

    assign pin_bus = {rate_sel, mod_en, pwr_dn_n};

    sscg_pin_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_bus),
        .q  (sync_bus)
    );

    always_comb begin
        s_cfg.sel  = rate_sel_e'(sync_bus[PIN_W-1:2]);
        s_cfg.en   = sync_bus[1];
        run        = sync_bus[0];
        active_cfg = valid_q ? cfg_q : s_cfg;
        prof       = decode_rate(active_cfg);
    end

    // Settings are frozen for a whole period and reloaded at its end
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{sel: SEL_CTR_WIDE, en: 1'b1};
            valid_q <= 1'b0;
        end else begin
            valid_q <= run;
            if (!valid_q || period_end) cfg_q <= s_cfg;
        end
    end

    sscg_period_dither #(
        .PMIN  (PMIN),
        .PSTEP (PSTEP),
        .LEVELS(DITHER_LEVELS),
        .QW    (QW)
    ) u_dither (
        .clk        (clk),
        .rst        (rst),
        .restart    (!run),
        .advance    (period_end),
        .quarter_len(quarter_len)
    );

    sscg_tri_stepper #(
        .QW(QW)
    ) u_stepper (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .quarter_len(quarter_len),
        .prof       (prof),
        .dev        (dev),
        .period_end (period_end)
    );

    assign dac_code     = CODE_MID + $unsigned(dev);
    assign code_valid   = valid_q;
    assign clk_hold_low = ~valid_q;

endmodule

// File: rtl/sscg_profile_gen_chk.sv
module sscg_profile_gen_chk
    import sscg_pkg::*;
#(
    parameter int PMIN  = 1600,
    parameter int PMAX  = 2200,
    parameter int PSTEP = 100
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] dac_code,
    input logic              code_valid,
    input logic              clk_hold_low,
    input logic              run,
    input logic              period_end,
    input mod_cfg_t          cfg_q
);

    localparam int CW = $clog2(PMAX + 1) + 1;

    logic [CW-1:0] len_cnt;
    logic [CW-1:0] last_len;
    logic          have_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            len_cnt   <= '0;
            last_len  <= '0;
            have_last <= 1'b0;
        end else if (period_end) begin
            len_cnt   <= '0;
            last_len  <= len_cnt + CW'(1);
            have_last <= 1'b1;
        end else begin
            len_cnt <= len_cnt + CW'(1);
        end
    end

    assert_code_span_R2: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (dac_code >= 8'd8 && dac_code <= 8'd188));

    assert_down_ceiling_R2: assert property (@(posedge clk) disable iff (rst)
        (code_valid && cfg_q.sel[1]) |-> (dac_code <= CODE_MID));

    assert_slew_R3: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(code_valid)) |->
            (dac_code == $past(dac_code) ||
             dac_code == $past(dac_code) + 8'd1 ||
             dac_code == $past(dac_code) - 8'd1));

    assert_period_bounds_R4: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (int'(len_cnt) + 1 >= PMIN && int'(len_cnt) + 1 <= PMAX));

    assert_period_walk_R4: assert property (@(posedge clk) disable iff (rst)
        (period_end && have_last) |->
            (int'(len_cnt) + 1 == int'(last_len) + PSTEP ||
             int'(len_cnt) + 1 == int'(last_len) - PSTEP));

    assert_mod_off_R7: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !cfg_q.en) |-> (dac_code == CODE_MID));

    assert_pd_mid_R8: assert property (@(posedge clk) disable iff (rst)
        clk_hold_low |-> (dac_code == CODE_MID));

    assert_restart_mid_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(code_valid) |-> (dac_code == CODE_MID));

endmodule

bind sscg_profile_gen sscg_profile_gen_chk #(
    .PMIN (PMIN),
    .PMAX (PMAX),
    .PSTEP(PSTEP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dac_code    (dac_code),
    .code_valid  (code_valid),
    .clk_hold_low(clk_hold_low),
    .run         (run),
    .period_end  (period_end),
    .cfg_q       (cfg_q)
);

// File: tb/sim_sscg_profile_gen.sv
module sim_sscg_profile_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] pin_sel;
    logic       pin_en;
    logic       pin_pd;
    logic [7:0] code0, code1;
    logic       valid0, valid1, hold0, hold1;

    int checks = 0;
    int errors = 0;
    int pmax_seen, pmin_seen;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sscg_profile_gen u0 (
        .clk(clk), .rst(rst), .rate_sel(pin_sel), .mod_en(pin_en), .pwr_dn_n(pin_pd),
        .dac_code(code0), .code_valid(valid0), .clk_hold_low(hold0)
    );

    sscg_profile_gen #(.X8_VARIANT(1'b1)) u1 (
        .clk(clk), .rst(rst), .rate_sel(pin_sel), .mod_en(pin_en), .pwr_dn_n(pin_pd),
        .dac_code(code1), .code_valid(valid1), .clk_hold_low(hold1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Closed-form triangle from R1..R3
    function automatic int exp_code(input int n, input int p, input logic [1:0] sel,
                                    input logic en);
        int q, s, seg, m, k, dev;
        q   = p / 4;
        s   = (sel == 2'b00 || sel == 2'b11) ? 60 : 20;
        if (!en) s = 0;
        seg = (n - 1) / q;
        m   = n - seg * q;
        k   = (m * s) / q;
        if (!sel[1]) begin
            case (seg)
                0: dev = k;
                1: dev = s - k;
                2: dev = -k;
                default: dev = -s + k;
            endcase
        end else begin
            case (seg)
                0: dev = -k;
                1: dev = -s - k;
                2: dev = -2 * s + k;
                default: dev = -s + k;
            endcase
        end
        return 128 + dev;
    endfunction

    // R4 ladder
    function automatic int period_of(input int k);
        int r;
        r = k % 12;
        return 1600 + 100 * ((r <= 6) ? r : 12 - r);
    endfunction

    task automatic check_period(input int p, input logic [1:0] sel, input logic en,
                                input int stop_at, input int chg_at,
                                input logic [1:0] nsel, input logic nen, input logic npd,
                                input bit x8chk, input string tag);
        int bad = 0, fa = 0, fe = 0, fn = 0;
        int xbad = 0, xa = 0, xe = 0;
        pmax_seen = 0;
        pmin_seen = 255;
        for (int n = 1; n <= stop_at; n++) begin
            int e;
            @(negedge clk);
            e = exp_code(n, p, sel, en);
            if (int'(code0) > pmax_seen) pmax_seen = int'(code0);
            if (int'(code0) < pmin_seen) pmin_seen = int'(code0);
            if (int'(code0) != e || !valid0 || hold0) begin
                if (bad == 0) begin fa = int'(code0); fe = e; fn = n; end
                bad++;
            end
            if (x8chk && n <= 640) begin
                int ex;
                ex = exp_code(n, 640, sel, en);
                if (int'(code1) != ex || !valid1) begin
                    if (xbad == 0) begin xa = int'(code1); xe = ex; end
                    xbad++;
                end
            end
            if (n == chg_at) begin
                pin_sel = nsel;
                pin_en  = nen;
                pin_pd  = npd;
            end
        end
        check(bad == 0, tag, $sformatf("profile P=%0d first bad sample %0d", p, fn), fa, fe);
        if (x8chk)
            check(xbad == 0, "R5", "x8 first period profile P=640", xa, xe);
    endtask

    task automatic t_reset_state();
        rst     = 1'b1;
        pin_sel = 2'b00;
        pin_en  = 1'b1;
        pin_pd  = 1'b0;
        repeat (4) @(negedge clk);
        check(valid0 == 1'b0, "R10", "valid in reset", int'(valid0), 0);
        check(hold0 == 1'b1, "R10", "hold_low in reset", int'(hold0), 1);
        check(code0 == 8'd128, "R10", "code in reset", int'(code0), 128);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(valid0 == 1'b0 && hold0 == 1'b1 && code0 == 8'd128, "R10",
              "idle after reset while powered down", int'(code0), 128);
    endtask

    task automatic t_power_up(input logic [1:0] sel, input logic en);
        pin_sel = sel;
        pin_en  = en;
        pin_pd  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(valid0 == 1'b0, "R9", "valid before third edge", int'(valid0), 0);
    endtask

    task automatic t_walk();
        // k0: wide centre, change to deep down at mid
        check_period(period_of(0), 2'b00, 1'b1, period_of(0), period_of(0) / 2,
                     2'b11, 1'b1, 1'b1, 1'b1, "R3 R6 k0");
        check(pmax_seen == 188 && pmin_seen == 68, "R2", "wide centre extremes max",
              pmax_seen, 188);
        check_period(period_of(1), 2'b11, 1'b1, period_of(1), period_of(1) / 2,
                     2'b01, 1'b1, 1'b1, 1'b0, "R3 R6 k1");
        check(pmax_seen == 128 && pmin_seen == 8, "R2", "deep down extremes min",
              pmin_seen, 8);
        check_period(period_of(2), 2'b01, 1'b1, period_of(2), period_of(2) / 2,
                     2'b10, 1'b1, 1'b1, 1'b0, "R3 R6 k2");
        check(pmax_seen == 148 && pmin_seen == 108, "R2", "narrow centre extremes max",
              pmax_seen, 148);
        check_period(period_of(3), 2'b10, 1'b1, period_of(3), period_of(3) / 2,
                     2'b10, 1'b0, 1'b1, 1'b0, "R3 R6 k3");
        check(pmax_seen == 128 && pmin_seen == 88, "R2", "shallow down extremes min",
              pmin_seen, 88);
        check_period(period_of(4), 2'b10, 1'b0, period_of(4), period_of(4) / 2,
                     2'b00, 1'b1, 1'b1, 1'b0, "R7 k4");
        check(pmax_seen == 128 && pmin_seen == 128, "R7", "flat period with enable low",
              pmin_seen, 128);
        check_period(period_of(5), 2'b00, 1'b1, period_of(5), 0,
                     2'b00, 1'b1, 1'b1, 1'b0, "R4 k5");
        check_period(period_of(6), 2'b00, 1'b1, period_of(6), period_of(6) / 2,
                     2'b11, 1'b1, 1'b1, 1'b0, "R4 R6 k6");
        for (int k = 7; k <= 12; k++)
            check_period(period_of(k), 2'b11, 1'b1, period_of(k), 0,
                         2'b11, 1'b1, 1'b1, 1'b0, $sformatf("R4 k%0d", k));
    endtask

    task automatic t_power_down_mid();
        // k13 (1700): drop power-down at sample 500
        check_period(period_of(13), 2'b11, 1'b1, 502, 500,
                     2'b11, 1'b1, 1'b0, 1'b0, "R4 k13");
        @(negedge clk);
        check(valid0 == 1'b0, "R8", "valid third edge after power-down", int'(valid0), 0);
        check(hold0 == 1'b1, "R8", "hold_low during power-down", int'(hold0), 1);
        check(code0 == 8'd128, "R8", "code during power-down", int'(code0), 128);
        check(valid1 == 1'b0, "R8", "x8 valid during power-down", int'(valid1), 0);
        pin_sel = 2'b10;
        pin_en  = 1'b1;
        repeat (30) @(negedge clk);
        check(code0 == 8'd128 && hold0 == 1'b1, "R8", "pins ignored in power-down",
              int'(code0), 128);
    endtask

    task automatic t_restart();
        t_power_up(2'b10, 1'b1);
        check_period(1600, 2'b10, 1'b1, 1600, 0, 2'b10, 1'b1, 1'b1, 1'b0,
                     "R9 R1 restart");
        check(pmin_seen == 88, "R9", "restart period reaches shallow trough", pmin_seen, 88);
    endtask

    initial begin
        t_reset_state();
        t_power_up(2'b00, 1'b1);
        t_walk();
        t_power_down_mid();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule